// File: doc/BRIEF.md
# Receive Descriptor Writeback Engine

This block moves completed receive frames from an upstream frame store into buffers that software has posted in a ring of descriptors in memory. It serves a 10/100 Ethernet MAC. Each descriptor takes 16 bytes and holds three 32-bit words: an ownership/status word, a control word carrying an end-of-ring flag and the buffer size, and the buffer byte address. When a frame is waiting, the engine reads the current descriptor over a single-outstanding memory request port. If hardware owns the descriptor and the buffer address is legal, the engine copies the frame into the buffer as halfword writes. It then writes the status word, which hands the descriptor back to software.

A descriptor that software still owns stops the engine. It reports a no-buffer event, keeps the frame pending and waits for a poll-demand strobe before it reads that descriptor again. The DMA path accepts a buffer only when its address is two-byte aligned and not four-byte aligned. Any other address produces a bus-error status with no data written. The ring index advances after each writeback. It returns to the ring base after a descriptor marked as the last one, or whenever the engine is disabled and idle.

Top module: `rx_desc_wb`

## Requirements
- R1: When a frame is waiting, the engine reads word 0 of the current descriptor at ring base + 16 × index. If bit 31 (owner) is 0, it raises ev_no_buf, keeps the frame pending (frm_done stays low) and makes no write.
- R2: After a no-buffer event the engine issues no memory request until poll_demand is strobed. It then fetches the same descriptor again.
- R3: A buffer address (word 2) is accepted only when bits 1:0 equal 2'b10. Otherwise no data is written, and the status word has bit 18 (bus error) set and length 0.
- R4: Frame bytes are written as halfwords in frame order, little-endian, at buffer address + 2k. A write to an address with bit 1 set uses byte enables 4'b1100, otherwise 4'b0011, and the mem_wdata halves both carry the halfword. Data writes never use enable 4'b1111.
- R5: The number of bytes copied is the smaller of frm_len and the buffer size in word 1 bits 10:0. When that count is odd, the last write enables only its low byte lane (4'b0100 or 4'b0001).
- R6: The status word is written to word 0 with byte enables 4'b1111 and has this layout: bit 31 = 0, bits 29 and 28 = 1, bits 22:19 = frm_err {odd nibble, runt, too long, CRC}, bit 18 = bus error, bits 17:16 = frm_cast {broadcast, multicast}, bits 10:0 = bytes copied, all other bits 0.
- R7: The status write is the last memory write of a frame. frm_done pulses for one cycle, in the cycle after the status write is granted.
- R8: ev_rx_ok pulses together with frm_done when status bits 22:18 are all 0. It stays low for any other writeback. ev_rx_ok and ev_no_buf are never high together.
- R9: After a writeback, the index goes to 0 if word 1 bit 31 was set, otherwise to index + 1.
- R10: While cfg_en is low, the engine starts no fetch, and the ring index returns to 0 once the engine is idle.
- R11: A memory request holds its address and write data stable until mem_gnt.
- R12: During reset, mem_req, frm_done, ev_rx_ok and ev_no_buf are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Engine enable |
| cfg_ring_base | input | AW | Ring base byte address, 16-byte aligned |
| poll_demand | input | 1 | Strobe that releases a no-buffer stall |
| frm_valid | input | 1 | A completed frame is waiting |
| frm_len | input | LENW | Frame length in bytes |
| frm_err | input | 4 | {odd nibble, runt, too long, CRC} |
| frm_cast | input | 2 | {broadcast, multicast} |
| frm_rd_idx | output | LENW-1 | Halfword index into the frame store |
| frm_rd_data | input | 16 | Halfword at frm_rd_idx, lower byte first |
| frm_done | output | 1 | Frame consumed |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| ev_rx_ok | output | 1 | Frame written without error |
| ev_no_buf | output | 1 | Current descriptor owned by software |

## Verification
The assertions take for granted that the ring base is 16-byte aligned and that read data returns at least one cycle after its grant, with only one read in flight. They also assume that frm_len and the frame flags stay stable while frm_valid is high. The bench memory model grants requests at random and returns reads one or two cycles after the grant. It programs a 16-byte-aligned base and changes frame inputs only while the engine has no frame in progress. A behavioural model reads the same descriptor memory to predict every write and event in order.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RWAIT,
    ST_DATA,
    ST_STAT,
    ST_DONE
  } rxr_state_e;

  localparam int OWN_BIT    = 31;
  localparam int END_BIT    = 31;
  localparam int FIRST_BIT  = 29;
  localparam int LAST_BIT   = 28;
  localparam int ERR_HI     = 22;
  localparam int ERR_LO     = 19;
  localparam int BUSERR_BIT = 18;
  localparam int CAST_HI    = 17;
  localparam int CAST_LO    = 16;
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int AW   = 32,
  parameter int IDXW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic          clr,
  input  logic          adv,
  input  logic          wrap,
  input  logic [1:0]    word_sel,
  output logic [AW-1:0] desc_addr
);
  logic [IDXW-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (clr)      idx_d = '0;
    else if (adv) idx_d = wrap ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign desc_addr = base + (AW'(idx_q) << 4) + (AW'(word_sel) << 2);
endmodule

// File: rtl/rxr_lane_pack.sv
module rxr_lane_pack #(
  parameter int AW   = 32,
  parameter int LENW = 11
) (
  input  logic [AW-1:0]   buf_addr,
  input  logic [LENW-1:0] hw_idx,
  input  logic [15:0]     hw_data,
  input  logic            last_odd,
  output logic [AW-1:0]   wr_addr,
  output logic [3:0]      wr_be,
  output logic [31:0]     wr_data
);
  logic [AW-1:0] byte_addr;

  always_comb begin
    byte_addr = buf_addr + (AW'(hw_idx) << 1);
    wr_addr   = {byte_addr[AW-1:2], 2'b00};
    if (byte_addr[1]) wr_be = last_odd ? 4'b0100 : 4'b1100;
    else              wr_be = last_odd ? 4'b0001 : 4'b0011;
    wr_data   = {hw_data, hw_data};
  end
endmodule

// File: rtl/rx_desc_wb.sv
module rx_desc_wb
  import rxr_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IDXW = 8,
  parameter int LENW = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic [AW-1:0]   cfg_ring_base,
  input  logic            poll_demand,
  input  logic            frm_valid,
  input  logic [LENW-1:0] frm_len,
  input  logic [3:0]      frm_err,
  input  logic [1:0]      frm_cast,
  output logic [LENW-2:0] frm_rd_idx,
  input  logic [15:0]     frm_rd_data,
  output logic            frm_done,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [3:0]      mem_be,
  output logic [31:0]     mem_wdata,
  input  logic            mem_gnt,
  input  logic            mem_rvalid,
  input  logic [31:0]     mem_rdata,
  output logic            ev_rx_ok,
  output logic            ev_no_buf
);
  rxr_state_e      state_q, state_d;
  logic [1:0]      sel_q, sel_d;
  logic            stall_q, stall_d;
  logic            end_q, end_d;
  logic [AW-1:0]   bufa_q, bufa_d;
  logic [LENW-1:0] clen_q, clen_d;
  logic [LENW-1:0] hw_q, hw_d;
  logic            berr_q, berr_d;
  logic            rxok_q, rxok_d;
  logic            nobuf_q, nobuf_d;
  logic            done_q, done_d;

  logic            adv, ptr_clr;
  logic [1:0]      ptr_sel;
  logic [AW-1:0]   desc_addr;
  logic [LENW:0]   hw_sum;
  logic [LENW-1:0] hw_total;
  logic            data_done, last_odd;
  logic [LENW-1:0] bsz;
  logic [AW-1:0]   lp_addr;
  logic [3:0]      lp_be;
  logic [31:0]     lp_data;
  logic [31:0]     stat_word;

  assign ptr_clr = !cfg_en && (state_q == ST_IDLE);
  assign ptr_sel = (state_q == ST_STAT) ? 2'b00 : sel_q;

  rxr_ring_ptr #(.AW(AW), .IDXW(IDXW)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .base      (cfg_ring_base),
    .clr       (ptr_clr),
    .adv       (adv),
    .wrap      (end_q),
    .word_sel  (ptr_sel),
    .desc_addr (desc_addr)
  );

  assign hw_sum    = {1'b0, clen_q} + 1'b1;
  assign hw_total  = hw_sum[LENW:1];
  assign data_done = (hw_q == hw_total);
  assign last_odd  = clen_q[0] && ((hw_q + 1'b1) == hw_total);
  assign bsz       = mem_rdata[LENW-1:0];

  rxr_lane_pack #(.AW(AW), .LENW(LENW)) u_lane (
    .buf_addr (bufa_q),
    .hw_idx   (hw_q),
    .hw_data  (frm_rd_data),
    .last_odd (last_odd),
    .wr_addr  (lp_addr),
    .wr_be    (lp_be),
    .wr_data  (lp_data)
  );

  always_comb begin
    stat_word                     = '0;
    stat_word[FIRST_BIT]          = 1'b1;
    stat_word[LAST_BIT]           = 1'b1;
    stat_word[ERR_HI:ERR_LO]      = frm_err;
    stat_word[BUSERR_BIT]         = berr_q;
    stat_word[CAST_HI:CAST_LO]    = frm_cast;
    stat_word[LENW-1:0]           = berr_q ? '0 : clen_q;
  end

  // next-state process
  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    stall_d = stall_q;
    end_d   = end_q;
    bufa_d  = bufa_q;
    clen_d  = clen_q;
    hw_d    = hw_q;
    berr_d  = berr_q;
    rxok_d  = 1'b0;
    nobuf_d = 1'b0;
    done_d  = 1'b0;
    adv     = 1'b0;
    if (poll_demand) stall_d = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cfg_en && frm_valid && !stall_q) begin
          state_d = ST_RD;
          sel_d   = 2'd0;
        end
      end
      ST_RD: begin
        if (mem_gnt) state_d = ST_RWAIT;
      end
      ST_RWAIT: begin
        if (mem_rvalid) begin
          case (sel_q)
            2'd0: begin
              if (!mem_rdata[OWN_BIT]) begin
                nobuf_d = 1'b1;
                stall_d = 1'b1;
                state_d = ST_IDLE;
              end else begin
                sel_d   = 2'd1;
                state_d = ST_RD;
              end
            end
            2'd1: begin
              end_d   = mem_rdata[END_BIT];
              clen_d  = (frm_len < bsz) ? frm_len : bsz;
              sel_d   = 2'd2;
              state_d = ST_RD;
            end
            default: begin
              bufa_d = mem_rdata[AW-1:0];
              hw_d   = '0;
              if (mem_rdata[1:0] == 2'b10) begin
                berr_d  = 1'b0;
                state_d = ST_DATA;
              end else begin
                berr_d  = 1'b1;
                state_d = ST_STAT;
              end
            end
          endcase
        end
      end
      ST_DATA: begin
        if (data_done)    state_d = ST_STAT;
        else if (mem_gnt) hw_d    = hw_q + 1'b1;
      end
      ST_STAT: begin
        if (mem_gnt) begin
          adv     = 1'b1;
          done_d  = 1'b1;
          rxok_d  = !(|frm_err) && !berr_q;
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= 2'd0;
      stall_q <= 1'b0;
      end_q   <= 1'b0;
      bufa_q  <= '0;
      clen_q  <= '0;
      hw_q    <= '0;
      berr_q  <= 1'b0;
      rxok_q  <= 1'b0;
      nobuf_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      stall_q <= stall_d;
      end_q   <= end_d;
      bufa_q  <= bufa_d;
      clen_q  <= clen_d;
      hw_q    <= hw_d;
      berr_q  <= berr_d;
      rxok_q  <= rxok_d;
      nobuf_q <= nobuf_d;
      done_q  <= done_d;
    end
  end

  assign mem_req    = (state_q == ST_RD) || (state_q == ST_STAT) ||
                      ((state_q == ST_DATA) && !data_done);
  assign mem_we     = (state_q == ST_DATA) || (state_q == ST_STAT);
  assign mem_addr   = (state_q == ST_DATA) ? lp_addr : desc_addr;
  assign mem_be     = (state_q == ST_DATA) ? lp_be : 4'hF;
  assign mem_wdata  = (state_q == ST_STAT) ? stat_word : lp_data;
  assign frm_rd_idx = hw_q[LENW-2:0];
  assign frm_done   = done_q;
  assign ev_rx_ok   = rxok_q;
  assign ev_no_buf  = nobuf_q;
endmodule

// File: rtl/rx_desc_wb_chk.sv
module rx_desc_wb_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          poll_demand,
  input logic          frm_done,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic [31:0]   mem_wdata,
  input logic          mem_gnt,
  input logic          ev_rx_ok,
  input logic          ev_no_buf
);
  logic held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           held_q <= 1'b0;
    else if (poll_demand) held_q <= 1'b0;
    else if (ev_no_buf)   held_q <= 1'b1;
  end

  AST_STAT_OWNER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_be == 4'hF) |-> (!mem_wdata[31] && mem_wdata[29] && mem_wdata[28])); // R6

  AST_DONE_AFTER_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> $past(mem_req && mem_gnt && mem_we && mem_be == 4'hF)); // R7

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_rx_ok && ev_no_buf)); // R8

  AST_RXOK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_ok |-> frm_done); // R8

  AST_STALL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_no_buf || held_q) |-> !mem_req); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata))); // R11

  AST_DATA_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_be != 4'hF) |->
      (mem_be == 4'b0011 || mem_be == 4'b1100 || mem_be == 4'b0001 || mem_be == 4'b0100)); // R4

  AST_DESC_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[3:0] == 4'h0 || mem_addr[3:0] == 4'h4 || mem_addr[3:0] == 4'h8)); // R1
endmodule

bind rx_desc_wb rx_desc_wb_chk #(.AW(AW)) u_chk (.*);

// File: tb/rx_desc_wb_tb.sv
module rx_desc_wb_tb;
  localparam logic [31:0] BASE = 32'h100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_en, poll_demand, frm_valid;
  logic [10:0] frm_len;
  logic [3:0]  frm_err;
  logic [1:0]  frm_cast;
  logic [9:0]  frm_rd_idx;
  logic [15:0] frm_rd_data;
  logic        frm_done, mem_req, mem_we, mem_gnt, mem_rvalid, ev_rx_ok, ev_no_buf;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  logic [31:0] mem [0:511];
  logic [7:0]  fbuf [0:2047];
  logic [31:0] qa[$], qd[$];
  logic [3:0]  qb[$];
  logic [2:0]  qe[$];
  logic [31:0] rd_hold;
  int rv_cnt, midx, req_cycles, checks, fails;

  always #4 clk = ~clk;

  rx_desc_wb u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_ring_base(BASE),
    .poll_demand(poll_demand), .frm_valid(frm_valid), .frm_len(frm_len),
    .frm_err(frm_err), .frm_cast(frm_cast), .frm_rd_idx(frm_rd_idx),
    .frm_rd_data(frm_rd_data), .frm_done(frm_done), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ev_rx_ok(ev_rx_ok), .ev_no_buf(ev_no_buf)
  );

  always_comb frm_rd_data = {fbuf[{frm_rd_idx, 1'b1}], fbuf[{frm_rd_idx, 1'b0}]};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  // memory model and per-clock comparison against the reference queues
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0; rv_cnt = 0;
    end else begin
      logic [2:0] evc;
      mem_rvalid = 1'b0;
      if (rv_cnt > 0) begin
        rv_cnt--;
        if (rv_cnt == 0) begin mem_rvalid = 1'b1; mem_rdata = rd_hold; end
      end
      evc = {ev_rx_ok, ev_no_buf, frm_done};
      if (evc != 3'b000) begin
        if (qe.size() == 0) chk(1'b0, "R8 R1 unexpected event", 32'(evc), 32'h0);
        else begin
          logic [2:0] e;
          e = qe.pop_front();
          chk(evc == e, "R8 R1 event", 32'(evc), 32'(e));
        end
      end
      mem_gnt = 1'b0;
      if (mem_req) begin
        req_cycles++;
        if ($urandom_range(3) != 0) begin
          mem_gnt = 1'b1;
          if (mem_we) begin
            logic [31:0] m;
            m = be_mask(mem_be);
            if (qa.size() == 0) chk(1'b0, "R7 unexpected write", mem_addr, 32'h0);
            else begin
              logic [31:0] ea, ed; logic [3:0] eb;
              ea = qa.pop_front(); ed = qd.pop_front(); eb = qb.pop_front();
              chk(mem_addr == ea && mem_be == eb && ((mem_wdata ^ ed) & be_mask(eb)) == 0,
                  (eb == 4'hF) ? "R6 R3 status write" : "R4 R5 data write",
                  mem_wdata & m, ed & be_mask(eb));
              if (mem_addr != ea || mem_be != eb)
                chk(1'b0, "R4 write address/enables", {mem_addr[27:0], mem_be}, {ea[27:0], eb});
            end
            mem[mem_addr[10:2]] = (mem[mem_addr[10:2]] & ~m) | (mem_wdata & m);
          end else begin
            rd_hold = mem[mem_addr[10:2]];
            rv_cnt  = $urandom_range(2, 1);
          end
        end
      end
    end
  end

  task automatic set_desc(input int i, input bit own, input bit last, input int bsz, input logic [31:0] ba);
    int w;
    w = (BASE + 32'(i * 16)) >> 2;
    mem[w]     = {own, 31'h0};
    mem[w + 1] = {last, 20'h0, 11'(bsz)};
    mem[w + 2] = ba;
  endtask

  // reference model: predicts the writes and events of the next attempt
  task automatic predict();
    logic [31:0] d, w0, w1, w2, st, a;
    logic [3:0]  be;
    logic [15:0] hw;
    int bsz, cp, nh;
    d  = BASE + 32'(midx * 16);
    w0 = mem[d[10:2]]; w1 = mem[d[10:2] + 1]; w2 = mem[d[10:2] + 2];
    if (!w0[31]) begin qe.push_back(3'b010); return; end
    bsz = int'(w1[10:0]);
    cp  = (int'(frm_len) < bsz) ? int'(frm_len) : bsz;
    st = '0; st[29] = 1'b1; st[28] = 1'b1; st[22:19] = frm_err; st[17:16] = frm_cast;
    if (w2[1:0] == 2'b10) begin
      nh = (cp + 1) / 2;
      for (int k = 0; k < nh; k++) begin
        bit odd;
        a   = w2 + 32'(2 * k);
        odd = (k == nh - 1) && (cp % 2 == 1);
        be  = a[1] ? (odd ? 4'b0100 : 4'b1100) : (odd ? 4'b0001 : 4'b0011);
        hw  = {fbuf[2 * k + 1], fbuf[2 * k]};
        qa.push_back(a & 32'hFFFF_FFFC); qb.push_back(be); qd.push_back({hw, hw});
      end
      st[10:0] = 11'(cp);
    end else st[18] = 1'b1;
    qa.push_back(d); qb.push_back(4'hF); qd.push_back(st);
    qe.push_back((st[22:18] == 5'd0) ? 3'b101 : 3'b001);
    midx = w1[31] ? 0 : midx + 1;
  endtask

  task automatic load_frame(input int len, input logic [3:0] err, input logic [1:0] cast, input int seed);
    for (int i = 0; i < 2048; i++) fbuf[i] = 8'(seed + i * 7);
    frm_len = 11'(len); frm_err = err; frm_cast = cast;
  endtask

  task automatic drain(input string tag);
    int t;
    t = 0;
    while (qe.size() != 0 && t < 4000) begin
      @(negedge clk); #1;
      if (frm_done) frm_valid = 1'b0;
      t++;
    end
    chk(qe.size() == 0 && qa.size() == 0, tag, 32'(qe.size() + qa.size()), 32'h0);
  endtask

  task automatic offer(input int len, input logic [3:0] err, input logic [1:0] cast, input int seed, input string tag);
    load_frame(len, err, cast, seed);
    predict();
    frm_valid = 1'b1;
    drain(tag);
  endtask

  task automatic poll();
    @(negedge clk); poll_demand = 1'b1;
    @(negedge clk); poll_demand = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int rc;
    rst_n = 1'b0; cfg_en = 1'b0; poll_demand = 1'b0; frm_valid = 1'b0;
    frm_len = '0; frm_err = '0; frm_cast = '0;
    midx = 0; req_cycles = 0; checks = 0; fails = 0;
    for (int i = 0; i < 512; i++) mem[i] = '0;
    for (int i = 0; i < 2048; i++) fbuf[i] = '0;
    repeat (3) @(negedge clk);
    chk(!mem_req && !frm_done && !ev_rx_ok && !ev_no_buf, "R12 reset outputs",
        {28'h0, mem_req, frm_done, ev_rx_ok, ev_no_buf}, 32'h0);
    set_desc(0, 1, 0, 100, 32'h402);
    set_desc(1, 1, 0, 64,  32'h504);
    set_desc(2, 1, 0, 40,  32'h602);
    set_desc(3, 1, 1, 64,  32'h701);
    rst_n = 1'b1;
    cfg_en = 1'b1;
    repeat (2) @(negedge clk);

    offer(61, 4'h0, 2'b00, 3, "R5 R4 odd frame into desc 0");
    offer(20, 4'h0, 2'b01, 9, "R3 four-byte-aligned buffer rejected");
    offer(60, 4'h0, 2'b00, 5, "R5 frame truncated to buffer size");
    offer(8,  4'h0, 2'b00, 1, "R3 odd buffer address rejected");
    set_desc(0, 1, 0, 100, 32'h402);
    offer(1,  4'h0, 2'b00, 4, "R9 wrap to desc 0, single byte");

    // descriptor 1 is still owned by software
    load_frame(2, 4'b0001, 2'b10, 11);
    predict();
    frm_valid = 1'b1;
    drain("R1 no-buffer event");
    chk(frm_valid == 1'b1, "R1 frame kept pending", 32'(frm_valid), 32'h1);
    rc = req_cycles;
    repeat (40) @(negedge clk);
    chk(req_cycles == rc, "R2 no request while stalled", 32'(req_cycles - rc), 32'h0);
    predict();
    poll();
    drain("R2 poll refetches, still software-owned");
    set_desc(1, 1, 0, 200, 32'h502);
    predict();
    poll();
    drain("R6 R8 error-flagged frame after poll");

    // disable: no fetch, index back to base
    @(negedge clk); cfg_en = 1'b0;
    repeat (5) @(negedge clk);
    set_desc(0, 1, 0, 100, 32'h402);
    load_frame(33, 4'h0, 2'b00, 21);
    frm_valid = 1'b1;
    rc = req_cycles;
    repeat (30) @(negedge clk);
    chk(req_cycles == rc, "R10 no fetch while disabled", 32'(req_cycles - rc), 32'h0);
    midx = 0;
    predict();
    cfg_en = 1'b1;
    drain("R10 restart at ring base");

    repeat (5) @(negedge clk);
    chk(qa.size() == 0 && qe.size() == 0, "R7 no leftover traffic", 32'(qa.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule